// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block takes one left and one right PCM sample per frame and shifts them out on one serial data line. The bit clock and the frame (word-select) clock both come from outside, so the block is a slave transmitter. Every internal register is updated on the falling edge of the bit clock. A receiver can therefore sample the line on the rising edge.

A single format input selects the framing. The first choice is MSB-justified framing: the left word goes out while the frame clock is high, and its most significant bit is in the first slot after the frame-clock edge. The second choice is I2S framing: the left word goes out while the frame clock is low, and every word starts one slot later. The block counts bit-clock cycles in each half-frame. If a half-frame is too short to carry 24 bits, the block sends only the upper 16 bits of each sample. Both samples are captured at the start of the frame, so the parallel inputs may change freely while the frame is being sent.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is asserted, and after release until the first frame-clock transition seen by the block, `sdata` is 0.
- R2: With `fmt_i2s`=0, the left channel is sent while `lrclk`=1. The MSB of the word is driven on the first falling bit-clock edge at which the block sees `lrclk` at its new level.
- R3: With `fmt_i2s`=1, the left channel is sent while `lrclk`=0. The MSB is driven on the second falling edge after the change, one slot later than in R2.
- R4: Data bits are sent in descending order: bit 23 first, then bit 22, and so on, so each two's complement word is sent MSB first.
- R5: If the previous half-frame lasted 24 or more bit-clock cycles, all 24 bits are sent. If it was shorter, bits 23 down to 8 are sent with no rounding.
- R6: After the last data bit of a slot, `sdata` is 0 until the next slot starts. In I2S mode, when the half-frame holds exactly as many cycles as data bits, the LSB is carried into the first slot of the following half.
- R7: `left_in` and `right_in` are both captured on the falling edge that starts a left half. Changes on these inputs later in the frame do not alter the bits being sent.
- R8: Half-frames of 16, 24, 32 and 64 bit-clock cycles are handled. Longer halves are filled with 0 after the data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state is updated on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Frame clock, one period per stereo frame |
| fmt_i2s | input | 1 | 0 selects MSB-justified framing, 1 selects I2S framing |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data output |

## Verification
Every output bit comes from one register that is updated on a falling bit-clock edge. The bit for slot k of a half is therefore stable from the k-th falling edge after the `lrclk` change (counting from 0) until the next falling edge. The bench reads the line 2 ns after each falling edge and compares it with a value computed from the slot number, the half-frame length, the format and the words the bench itself chose for that frame. The first frame after each reset is only used to prime the length measurement and is not checked. The bench drives `lrclk` and the parallel inputs just after a falling edge, so the next falling edge is the one that must act on them.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int CNT_W    = 8
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lrclk,
  input  logic                fmt_i2s,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   LONG_LEN = (CNT_W+1)'(SAMPLE_W);
  localparam logic [CNT_W:0]   SHRT_LEN = (CNT_W+1)'(SHORT_W);

  logic                lr_q, primed, measured, wide, sdata_q;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] l_buf, r_buf;

  wire edge_lr     = primed && (lrclk != lr_q);
  wire is_left     = fmt_i2s ? ~lrclk : lrclk;
  wire frame_start = edge_lr && is_left;

  wire [CNT_W-1:0] pos      = edge_lr ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
  wire [CNT_W:0]   half_len = {1'b0, cnt} + 1'b1;
  wire             wide_now = (edge_lr && measured) ? (half_len >= LONG_LEN) : wide;

  wire [CNT_W:0] w_now = wide_now ? LONG_LEN : SHRT_LEN;
  wire [CNT_W:0] w_old = wide ? LONG_LEN : SHRT_LEN;

  wire [SAMPLE_W-1:0] cur_word  = frame_start ? left_in : (is_left ? l_buf : r_buf);
  wire [SAMPLE_W-1:0] prev_word = is_left ? r_buf : l_buf;

  wire [CNT_W:0] pos_x   = {1'b0, pos};
  wire [CNT_W:0] idx     = pos_x - {{CNT_W{1'b0}}, fmt_i2s};
  wire           in_data = (pos_x >= {{CNT_W{1'b0}}, fmt_i2s}) && (idx < w_now);
  wire           spill   = edge_lr && fmt_i2s && measured && (half_len == w_old);

  logic next_bit;
  always_comb begin
    next_bit = 1'b0;
    if (spill)
      next_bit = prev_word[SAMPLE_W - int'(w_old)];
    else if (in_data)
      next_bit = cur_word[SAMPLE_W - 1 - int'(idx)];
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q     <= 1'b0;
      primed   <= 1'b0;
      measured <= 1'b0;
      wide     <= 1'b1;
      cnt      <= '0;
      l_buf    <= '0;
      r_buf    <= '0;
      sdata_q  <= 1'b0;
    end else begin
      lr_q    <= lrclk;
      primed  <= 1'b1;
      cnt     <= pos;
      wide    <= wide_now;
      sdata_q <= next_bit;
      if (edge_lr) measured <= 1'b1;
      if (frame_start) begin
        l_buf <= left_in;
        r_buf <= right_in;
      end
    end
  end

  assign sdata = sdata_q;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int CNT_W    = 8
) (
  input logic                bclk,
  input logic                rst_n,
  input logic                fmt_i2s,
  input logic                sdata,
  input logic                lr_q,
  input logic                primed,
  input logic                measured,
  input logic                wide,
  input logic [CNT_W-1:0]    cnt,
  input logic [SAMPLE_W-1:0] l_buf,
  input logic [SAMPLE_W-1:0] r_buf
);

  wire [CNT_W:0] width_bits = wide ? (CNT_W+1)'(SAMPLE_W) : (CNT_W+1)'(SHORT_W);

  // R1: line stays low before the first sampled edge
  a_r1_idle_low: assert property (@(posedge bclk) disable iff (!rst_n)
    !primed |-> !sdata);

  // R2: MSB-justified slot 0 carries bit 23 of the captured word
  a_r2_msb_slot0: assert property (@(posedge bclk) disable iff (!rst_n)
    (!fmt_i2s && measured && cnt == '0) |->
      (sdata == (lr_q ? l_buf[SAMPLE_W-1] : r_buf[SAMPLE_W-1])));

  // R6: tail of an MSB-justified slot is low
  a_r6_tail_low: assert property (@(posedge bclk) disable iff (!rst_n)
    (!fmt_i2s && primed && ({1'b0, cnt} >= width_bits)) |-> !sdata);

  // R5: width decision only moves at a half-frame boundary
  a_r5_width_at_edge: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(wide) |-> (cnt == '0));

  // R7: captured words only move at a half-frame boundary
  a_r7_capture_at_edge: assert property (@(posedge bclk) disable iff (!rst_n)
    (!$stable(l_buf) || !$stable(r_buf)) |-> (cnt == '0));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(
  .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)
) u_chk (
  .bclk(bclk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .sdata(sdata),
  .lr_q(lr_q), .primed(primed), .measured(measured), .wide(wide),
  .cnt(cnt), .l_buf(l_buf), .r_buf(r_buf)
);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic [23:0] left_in = '0;
  logic [23:0] right_in = '0;
  logic        sdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] seed = 24'h5A3C1F;

  always #4 bclk = ~bclk;

  audio_ser_tx u_audio_ser_tx (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .fmt_i2s(fmt_i2s),
    .left_in(left_in), .right_in(right_in), .sdata(sdata)
  );

  function automatic logic [23:0] next_word(logic [23:0] s);
    return s * 24'd1103515 + 24'd12345;
  endfunction

  function automatic logic exp_bit(bit f, int h, int k, logic [23:0] w, logic [23:0] wp);
    int wb = (h >= 24) ? 24 : 16;
    if (!f) return (k < wb) ? w[23-k] : 1'b0;
    if (k == 0) return (h == wb) ? wp[24-wb] : 1'b0;
    return (k - 1 < wb) ? w[24-k] : 1'b0;
  endfunction

  function automatic string tag_of(bit f, int h, int k, bit left_half);
    int wb = (h >= 24) ? 24 : 16;
    int d = k - (f ? 1 : 0);
    if (d == 0) return f ? "R3" : "R2";
    if (d < 0 || d >= wb) return (h == 64) ? "R8" : "R6";
    if (wb == 16) return "R5";
    if (left_half && k > 2) return "R7";
    return "R4";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sdata=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(bit f, int h, int frames);
    logic [23:0] lw, rw, prev;
    fmt_i2s = f;
    rst_n   = 1'b0;
    lrclk   = f;
    prev    = '0;
    repeat (2) @(negedge bclk);
    #2 check("R1", sdata, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge bclk); #2;
      check("R1", sdata, 1'b0);
    end
    for (int fr = 0; fr < frames; fr++) begin
      seed = next_word(seed); lw = seed;
      seed = next_word(seed); rw = seed;
      left_in  = lw;
      right_in = rw;
      lrclk    = ~f;
      for (int half = 0; half < 2; half++) begin
        logic [23:0] w;
        w = half ? rw : lw;
        for (int k = 0; k < h; k++) begin
          @(negedge bclk); #2;
          if (fr > 0) check(tag_of(f, h, k, half == 0), sdata, exp_bit(f, h, k, w, prev));
          if (half == 0 && k == 2) begin
            left_in  = ~lw;
            right_in = rw ^ 24'hA5A5A5;
          end
          if (half == 0 && k == h - 1) lrclk = f;
        end
        prev = w;
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 2; f++) begin
      run_cfg(f[0], 16, 5);
      run_cfg(f[0], 24, 5);
      run_cfg(f[0], 32, 5);
      run_cfg(f[0], 64, 4);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule